// File: doc/BRIEF.md
# Read-Strobe Gate Window Calibrator

This block is the control state machine that places the gating enable of a read strobe during memory interface bring-up. It owns three settings that together set when the gate closes. The first is a whole-cycle shift applied to the read-enable FIFO. The second is one of eight coarse clock phases, each about 45 degrees. The third is a fine delay tap within one phase. The phase generator, the delay line, the memory and the read-compare engine all sit outside the block. Only the setting registers and a request/acknowledge handshake with the compare engine connect it to them.

After `start`, the block keeps the output-latency FIFO pinned at full depth. It then steps through candidate settings in whole-phase strides, rolling into the next cycle after phase 7. After each change it waits a programmable settle time, then asks the compare engine for a verdict. A verdict passes when any bit of the group passes, because the bits have not been deskewed yet. Once both edges of the passing window are known, they are refined to single-tap resolution. The block then programs the midpoint and raises `done`. If the cycle range runs out before both edges are found, it raises `fail` instead.

Top module: `dqs_gate_cal`

## Requirements
- R1: While `rst_n` is low, and after its release until `start`, the block drives `test_req`, `done`, `fail` and `lfifo_max` low and the settings `vfifo_cyc`, `phase_sel` and `tap_sel` to 0.
- R2: `lfifo_max` is high on every cycle in which calibration is in progress (from the cycle after an accepted `start` until `done` or `fail` rises). It is low otherwise.
- R3: After an accepted `start`, and after each acknowledged test that does not end calibration, `test_req` rises exactly `settle_cnt`+1 cycles later, with the settings already updated.
- R4: Once raised, `test_req` stays high with the settings unchanged until `test_ack` is sampled high. It is low in the following cycle.
- R5: A test passes when any bit of `test_pass` is 1 in the cycle `test_ack` is high. An all-zero vector is a failure.
- R6: The linear position of a setting is (`vfifo_cyc`*8 + `phase_sel`)*TAPS + `tap_sel`. The coarse search starts at position 0 and advances by TAPS (one phase), so the phase wraps from 7 to 0 as the cycle count increments.
- R7: The leading edge found is the lowest passing position, resolved to one tap by retesting the taps between the last failing and the first passing phase.
- R8: The trailing edge found is the highest passing position, resolved to one tap between the last passing and the first failing phase.
- R9: When both edges are found, the settings become floor((lead+trail)/2) in the R6 encoding, `done` goes high and `fail` stays low, and both hold until the next accepted `start`.
- R10: If a coarse step would pass the last position ((2^CYC_W)*8*TAPS-1) before both edges are found, `fail` goes high, `done` stays low, and the settings keep the last tested value.
- R11: `start` is accepted only when idle, done or failed. Acceptance clears `done` and `fail` and restarts the search at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run |
| settle_cnt | input | SETTLE_W | Idle cycles after a setting change, minus one |
| test_ack | input | 1 | Compare engine verdict is valid |
| test_pass | input | DQ_W | Per-bit pass flags of the verdict |
| test_req | output | 1 | Request a read-compare at current settings |
| vfifo_cyc | output | CYC_W | Whole-cycle shift of the read enable |
| phase_sel | output | 3 | Coarse phase index (0..7) |
| tap_sel | output | TAP_W | Fine delay tap index |
| lfifo_max | output | 1 | Hold the output-latency FIFO at full depth |
| done | output | 1 | Calibration finished, gate centred |
| fail | output | 1 | No complete window within the cycle range |

## Verification
A wrong internal stage or edge register shows first in the sequence of settings offered with `test_req`. This can be a tap retested out of order, a coarse step that skips a phase, or a wrong number of verdicts requested, and it appears within one settle period of the mistake. A wrong lead or trail value stays hidden until the end and then surfaces as final settings that miss the window midpoint, or as `fail` where `done` was due. The bench therefore counts the verdicts per run, checks the settle spacing at every request, and compares the final position against the midpoint of the window that its model engine exposes.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;
  localparam int unsigned PHASES_PER_CYC = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_TEST,
    ST_DONE,
    ST_FAIL
  } cal_state_e;

  typedef enum logic [1:0] {
    SG_LEAD_COARSE,
    SG_LEAD_FINE,
    SG_TRAIL_COARSE,
    SG_TRAIL_FINE
  } cal_stage_e;
endpackage

// File: rtl/dqs_cal_timer.sv
module dqs_cal_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (!expired)  cnt_q <= cnt_q + W'(1);
  end

  assign expired = run && (cnt_q == limit);

  // R3: the settle window is never abandoned before it expires
  p_settle_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !expired |=> run);
endmodule

// File: rtl/dqs_cal_split.sv
module dqs_cal_split #(
  parameter int CYC_W = 3,
  parameter int TAPS  = 4,
  parameter int TAP_W = 2,
  parameter int POS_W = 8
) (
  input  logic [POS_W-1:0] pos,
  output logic [CYC_W-1:0] cyc,
  output logic [2:0]       phase,
  output logic [TAP_W-1:0] tap
);
  localparam logic [POS_W-1:0] TAPS_P  = POS_W'(TAPS);
  localparam logic [POS_W-1:0] CYCLE_P = POS_W'(TAPS * 8);

  logic [POS_W-1:0] coarse;

  assign coarse = pos / TAPS_P;
  assign tap    = TAP_W'(pos % TAPS_P);
  assign phase  = coarse[2:0];
  assign cyc    = CYC_W'(pos / CYCLE_P);
endmodule

// File: rtl/dqs_gate_cal.sv
module dqs_gate_cal #(
  parameter int CYC_W    = 3,
  parameter int TAPS     = 4,
  parameter int DQ_W     = 8,
  parameter int SETTLE_W = 6,
  localparam int TAP_W   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cnt,
  input  logic                test_ack,
  input  logic [DQ_W-1:0]     test_pass,
  output logic                test_req,
  output logic [CYC_W-1:0]    vfifo_cyc,
  output logic [2:0]          phase_sel,
  output logic [TAP_W-1:0]    tap_sel,
  output logic                lfifo_max,
  output logic                done,
  output logic                fail
);
  import dqs_cal_pkg::*;

  localparam int POS_W   = CYC_W + 3 + TAP_W;
  localparam int MAX_POS = (1 << CYC_W) * PHASES_PER_CYC * TAPS - 1;
  localparam logic [POS_W:0]   STEP_W = (POS_W+1)'(TAPS);
  localparam logic [POS_W:0]   LIMIT  = (POS_W+1)'(MAX_POS);
  localparam logic [POS_W-1:0] BACK   = POS_W'(TAPS - 1);
  localparam logic [POS_W-1:0] ONE    = POS_W'(1);

  function automatic logic [POS_W-1:0] mid_pos(input logic [POS_W-1:0] a,
                                                input logic [POS_W-1:0] b);
    logic [POS_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[POS_W:1];
  endfunction

  cal_state_e       st_q;
  cal_stage_e       stage_q;
  logic [POS_W-1:0] pos_q, lead_q, trail_q, cref_q;

  // named internal events
  logic           hit, start_acc, test_fire, settle_done;
  logic [POS_W:0] pos_step, ref_step;
  logic           step_ok, ref_ok, fine_last;

  assign hit       = |test_pass;
  assign start_acc = start && (st_q == ST_IDLE || st_q == ST_DONE || st_q == ST_FAIL);
  assign test_fire = (st_q == ST_TEST) && test_ack;
  assign pos_step  = {1'b0, pos_q} + STEP_W;
  assign ref_step  = {1'b0, cref_q} + STEP_W;
  assign step_ok   = pos_step <= LIMIT;
  assign ref_ok    = ref_step <= LIMIT;
  assign fine_last = (pos_q + ONE) == cref_q;

  dqs_cal_timer #(.W(SETTLE_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st_q == ST_SETTLE),
    .limit  (settle_cnt),
    .expired(settle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      stage_q <= SG_LEAD_COARSE;
      pos_q   <= '0;
      lead_q  <= '0;
      trail_q <= '0;
      cref_q  <= '0;
    end else begin
      case (st_q)
        ST_SETTLE: if (settle_done) st_q <= ST_TEST;
        ST_TEST: if (test_ack) begin
          st_q <= ST_SETTLE;
          case (stage_q)
            SG_LEAD_COARSE: begin
              if (hit) begin
                cref_q <= pos_q;
                if (pos_q == '0 || TAPS == 1) begin
                  lead_q  <= pos_q;
                  stage_q <= SG_TRAIL_COARSE;
                  if (step_ok) pos_q <= pos_step[POS_W-1:0];
                  else         st_q  <= ST_FAIL;
                end else begin
                  pos_q   <= pos_q - BACK;
                  stage_q <= SG_LEAD_FINE;
                end
              end else if (step_ok) pos_q <= pos_step[POS_W-1:0];
              else                  st_q  <= ST_FAIL;
            end
            SG_LEAD_FINE: begin
              if (hit || fine_last) begin
                lead_q  <= hit ? pos_q : cref_q;
                stage_q <= SG_TRAIL_COARSE;
                if (ref_ok) pos_q <= ref_step[POS_W-1:0];
                else        st_q  <= ST_FAIL;
              end else pos_q <= pos_q + ONE;
            end
            SG_TRAIL_COARSE: begin
              if (hit) begin
                if (step_ok) pos_q <= pos_step[POS_W-1:0];
                else         st_q  <= ST_FAIL;
              end else begin
                cref_q <= pos_q;
                if (TAPS == 1) begin
                  trail_q <= pos_q - ONE;
                  pos_q   <= mid_pos(lead_q, pos_q - ONE);
                  st_q    <= ST_DONE;
                end else begin
                  pos_q   <= pos_q - BACK;
                  stage_q <= SG_TRAIL_FINE;
                end
              end
            end
            default: begin
              if (!hit) begin
                trail_q <= pos_q - ONE;
                pos_q   <= mid_pos(lead_q, pos_q - ONE);
                st_q    <= ST_DONE;
              end else if (fine_last) begin
                trail_q <= pos_q;
                pos_q   <= mid_pos(lead_q, pos_q);
                st_q    <= ST_DONE;
              end else pos_q <= pos_q + ONE;
            end
          endcase
        end
        default: if (start_acc) begin
          st_q    <= ST_SETTLE;
          stage_q <= SG_LEAD_COARSE;
          pos_q   <= '0;
        end
      endcase
    end
  end

  dqs_cal_split #(.CYC_W(CYC_W), .TAPS(TAPS), .TAP_W(TAP_W), .POS_W(POS_W)) u_split (
    .pos  (pos_q),
    .cyc  (vfifo_cyc),
    .phase(phase_sel),
    .tap  (tap_sel)
  );

  assign test_req  = (st_q == ST_TEST);
  assign lfifo_max = (st_q == ST_SETTLE) || (st_q == ST_TEST);
  assign done      = (st_q == ST_DONE);
  assign fail      = (st_q == ST_FAIL);

  // ---------------- assertions ----------------
  logic [SETTLE_W+1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       gap_q <= '0;
    else if (start_acc || test_fire)  gap_q <= '0;
    else if (gap_q != '1)             gap_q <= gap_q + (SETTLE_W+2)'(1);
  end

  p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_req) |-> gap_q == ({2'b00, settle_cnt} + (SETTLE_W+2)'(1)));
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && !test_ack |=> test_req && $stable(pos_q));
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && test_ack |=> !test_req);
  p_lfifo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |-> lfifo_max);
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  p_centre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lead_q <= trail_q) && (pos_q >= lead_q) && (pos_q <= trail_q));
  p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail && $stable(pos_q));
endmodule

// File: tb/sim_dqs_gate_cal.sv
module sim_dqs_gate_cal;
  localparam int CYC_W = 3, TAPS = 4, DQ_W = 8, SETTLE_W = 6;
  localparam int TAP_W = 2;
  localparam int LAST  = (1 << CYC_W) * 8 * TAPS - 1;

  logic clk = 0, rst_n = 0, start = 0, test_ack = 0;
  logic [SETTLE_W-1:0] settle_cnt = '0;
  logic [DQ_W-1:0] test_pass = '0;
  logic test_req, lfifo_max, done, fail;
  logic [CYC_W-1:0] vfifo_cyc;
  logic [2:0] phase_sel;
  logic [TAP_W-1:0] tap_sel;

  dqs_gate_cal #(.CYC_W(CYC_W), .TAPS(TAPS), .DQ_W(DQ_W), .SETTLE_W(SETTLE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cnt(settle_cnt),
    .test_ack(test_ack), .test_pass(test_pass), .test_req(test_req),
    .vfifo_cyc(vfifo_cyc), .phase_sel(phase_sel), .tap_sel(tap_sel),
    .lfifo_max(lfifo_max), .done(done), .fail(fail));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int win_lo = 1000, win_hi = 0, ack_delay = 0, settle_v = 0;
  logic [DQ_W-1:0] pattern = 8'h01;
  int n_tests = 0, gap_bad = 0, lfifo_bad = 0;
  bit summary_done = 0;

  function automatic int pos_now();
    return (int'(vfifo_cyc) * 8 + int'(phase_sel)) * TAPS + int'(tap_sel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model compare engine
  initial begin
    int wait_c;
    wait_c = 0;
    forever begin
      @(negedge clk);
      if (test_ack) begin
        test_ack = 0;
        test_pass = '0;
      end else if (test_req) begin
        if (wait_c < ack_delay) wait_c++;
        else begin
          int p;
          p = pos_now();
          n_tests++;
          if (!lfifo_max) lfifo_bad++;
          test_pass = (p >= win_lo && p <= win_hi) ? pattern : '0;
          test_ack = 1;
          wait_c = 0;
        end
      end
    end
  end

  // settle-spacing monitor
  initial begin
    int last_p, gap;
    logic req_prev;
    last_p = 0; gap = 100; req_prev = 0;
    forever begin
      @(negedge clk);
      if (pos_now() != last_p) gap = 0; else if (gap < 1000) gap++;
      last_p = pos_now();
      if (test_req && !req_prev && gap < settle_v + 1) gap_bad++;
      req_prev = test_req;
    end
  end

  task automatic run_cal(input int lo, input int hi, input int s, input logic [DQ_W-1:0] pat);
    int t;
    win_lo = lo; win_hi = hi; settle_v = s; pattern = pat;
    settle_cnt = SETTLE_W'(s);
    n_tests = 0; gap_bad = 0; lfifo_bad = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(lfifo_max == 1 && done == 0 && fail == 0, "R2/R11 busy after start",
          int'(lfifo_max), 1);
    t = 0;
    while (!done && !fail && t < 5000) begin @(negedge clk); t++; end
    check(t < 5000, "R9 run completes", t, 0);
    check(gap_bad == 0, "R3 settle spacing", gap_bad, 0);
    check(lfifo_bad == 0, "R2 lfifo_max during tests", lfifo_bad, 0);
    check(lfifo_max == 0, "R2 lfifo_max released", int'(lfifo_max), 0);
  endtask

  task automatic expect_done(input int lo, input int hi, input string tag);
    int m;
    m = (lo + hi) / 2;
    check(done == 1 && fail == 0, {tag, " done flag"}, int'(done), 1);
    check(pos_now() == m, {tag, " centred position"}, pos_now(), m);
    repeat (3) @(negedge clk);
    check(done == 1 && pos_now() == m, "R9 result holds", pos_now(), m);
  endtask

  task automatic t_reset();
    check(test_req == 0 && done == 0 && fail == 0 && lfifo_max == 0, "R1 flags",
          int'({test_req, done, fail, lfifo_max}), 0);
    check(pos_now() == 0, "R1 settings", pos_now(), 0);
  endtask

  task automatic t_mid_window();
    run_cal(10, 25, 0, 8'h01);
    expect_done(10, 25, "R7 R8 R9 mid window");
    check(vfifo_cyc == 0 && phase_sel == 4 && tap_sel == 1, "R6 fields of 17",
          int'(phase_sel), 4);
    check(n_tests == 12, "R7 R8 verdict count", n_tests, 12);
  endtask

  task automatic t_origin();
    run_cal(0, 5, 1, 8'h80);
    expect_done(0, 5, "R5 R7 window at origin");
    check(n_tests == 5, "R7 origin verdict count", n_tests, 5);
  endtask

  task automatic t_cycle_cross();
    run_cal(29, 47, 2, 8'h24);
    expect_done(29, 47, "R6 cycle crossing");
    check(vfifo_cyc == 1 && phase_sel == 1 && tap_sel == 2, "R6 fields of 38",
          int'(vfifo_cyc), 1);
  endtask

  task automatic t_aligned();
    run_cal(12, 19, 0, 8'h10);
    expect_done(12, 19, "R7 R8 phase-aligned edges");
    check(n_tests == 12, "R8 aligned verdict count", n_tests, 12);
  endtask

  task automatic t_slow();
    ack_delay = 3;
    run_cal(10, 25, 5, 8'h02);
    expect_done(10, 25, "R3 R4 slow engine");
    ack_delay = 0;
  endtask

  task automatic t_no_window();
    run_cal(LAST + 10, LAST + 20, 0, 8'h01);
    check(fail == 1 && done == 0, "R10 no window fail", int'(fail), 1);
    check(pos_now() == LAST - TAPS + 1, "R10 last settings", pos_now(), LAST - TAPS + 1);
    repeat (4) @(negedge clk);
    check(fail == 1 && pos_now() == LAST - TAPS + 1, "R10 fail holds", pos_now(), LAST - TAPS + 1);
  endtask

  task automatic t_top_edge();
    run_cal(240, LAST, 0, 8'hFF);
    check(fail == 1 && done == 0, "R10 trail past range", int'(fail), 1);
    check(pos_now() == LAST - TAPS + 1, "R10 top last settings", pos_now(), LAST - TAPS + 1);
  endtask

  task automatic t_restart();
    run_cal(33, 60, 0, 8'h01);
    check(fail == 0, "R11 fail cleared on restart", int'(fail), 0);
    expect_done(33, 60, "R11 restart after fail");
  endtask

  task automatic t_busy_start();
    int t;
    win_lo = 10; win_hi = 25; settle_cnt = '0; settle_v = 0; n_tests = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    t = 0;
    while (!done && !fail && t < 5000) begin @(negedge clk); t++; end
    check(n_tests == 12, "R11 start ignored while busy", n_tests, 12);
    expect_done(10, 25, "R11 busy start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mid_window();
    t_origin();
    t_cycle_cross();
    t_aligned();
    t_slow();
    t_no_window();
    t_top_edge();
    t_restart();
    t_busy_start();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end
endmodule